// File: doc/BRIEF.md
# Multi-Chain Scan Self-Test Sequencer

This block drives a scan-based self-test over a set of parallel scan chains that live outside it. A single pseudo-random generator produces the stimulus. A small XOR network spreads that stimulus across the chains so that neighbouring chains do not carry delayed copies of one stream. The chain outputs are folded into a multiple-input signature register that has one bit per chain, not one bit per observed flop.

A run starts with a pulse on `start` while the block is idle and `pat_cnt` is nonzero. The block then loads a pattern by shifting every chain for `CHAIN_LEN` clocks with `scan_en` high. It drops `scan_en` for a single functional capture clock and then shifts again. Each later shift loads the next pattern while the previous response is unloaded into the signature register. After the last capture, one further shift unloads the final response with zero stimulus. `done` then rises and `signature` holds the result until the next accepted start.

Top module: `scanbist_ctrl`

## Requirements
- R1: While reset is asserted and after its release, before any start: `scan_en`=0, `done`=0, `signature`=0 and `scan_in`=0.
- R2: The generator is a 16-bit register loaded with 16'hACE1 when a start is accepted. It advances once in every load-shift cycle as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R3: In a load-shift cycle, `scan_in[k]` = s[a]^s[b] with a = k mod 16 and b = (a + 1 + k/16) mod 16, where s is the generator state in that cycle. In every other cycle, including the final unload, `scan_in` is all zeros.
- R4: Every shift phase is exactly `CHAIN_LEN` (default 200) consecutive cycles with `scan_en`=1.
- R5: Each load is followed by exactly one cycle with `scan_en`=0 (capture). That cycle is followed by the next load or by the final unload.
- R6: Counting c=0 from the cycle after the accepting edge, for P patterns and length L: `scan_en`=0 exactly when c = p(L+1)+L for p < P, and when c >= P(L+1)+L.
- R7: `signature` is cleared to 0 when a start is accepted. In every shift cycle except those of the first load, it updates from the chain outputs d: bit0 <= sig[24]^d[0]; bit i <= sig[i-1]^d[i], with sig[24] also XORed in for i=3.
- R8: After the last capture, one unload of `CHAIN_LEN` cycles runs. `done` rises in the cycle c = P(L+1)+L. `scan_en` is 0 whenever `done` is 1.
- R9: While idle after a run, `done` and `signature` hold their values until the next accepted start.
- R10: A start is accepted only when idle and `pat_cnt` is nonzero. A start with `pat_cnt`=0 leaves `scan_en` at 0 and `done` and `signature` unchanged. A start during a run has no effect on that run.
- R11: The pattern count is taken at the accepting edge. Later changes of `pat_cnt` during the run do not alter its length.
- R12: `done` is 0 from the cycle after an accepted start until the end of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a run |
| pat_cnt | input | PAT_W (16) | Number of patterns for the run |
| scan_en | output | 1 | Shift enable for all chains; low means functional capture |
| scan_in | output | NCHAINS (25) | Serial stimulus, one bit per chain |
| scan_out | input | NCHAINS (25) | Serial response, one bit per chain |
| done | output | 1 | Run finished; signature valid |
| signature | output | NCHAINS (25) | Signature register contents |

## Verification
Several properties are checked on every cycle:
- each shift phase lasts exactly the chain length;
- a single capture cycle separates shifts;
- stimulus is quiet outside loading;
- `done` excludes shifting;
- the signature holds while finished;
- a zero-count start is ignored.

Other behaviour can only be shown by the bench's scenarios against its own chain model and reference generator and compactor:
- the exact stimulus bit values and the exact signature value;
- the exclusion of the first load from compaction;
- the clearing of the signature between runs;
- the immunity of a run to a second start or a changed count.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    SBC_IDLE  = 2'd0,
    SBC_LOAD  = 2'd1,
    SBC_CAPT  = 2'd2,
    SBC_FLUSH = 2'd3
  } sbc_state_e;

  // First generator bit feeding phase-shifter output k
  function automatic int ps_tap_a(input int k, input int lw);
    return k % lw;
  endfunction

  // Second generator bit feeding phase-shifter output k
  function automatic int ps_tap_b(input int k, input int lw);
    return ((k % lw) + 1 + (k / lw)) % lw;
  endfunction

endpackage

// File: rtl/sbc_lfsr.sv
module sbc_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_en,
  input  logic         step_en,
  output logic [W-1:0] state
);

  logic [W-1:0] state_d;

  always_comb begin
    state_d = state;
    if (seed_en)      state_d = SEED;
    else if (step_en) state_d = {state[W-2:0], ^(state & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end

endmodule

// File: rtl/sbc_phase_shift.sv
module sbc_phase_shift #(
  parameter int LW  = 16,
  parameter int NCH = 25
) (
  input  logic [LW-1:0]  gen,
  input  logic           en,
  output logic [NCH-1:0] chain_in
);

  for (genvar k = 0; k < NCH; k++) begin : g_out
    localparam int TA = sbc_pkg::ps_tap_a(k, LW);
    localparam int TB = sbc_pkg::ps_tap_b(k, LW);
    assign chain_in[k] = en & (gen[TA] ^ gen[TB]);
  end

endmodule

// File: rtl/sbc_misr.sv
module sbc_misr #(
  parameter int          W    = 25,
  parameter logic [W-1:0] TAPS = 25'h0000008
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] sig_d;
  logic         fb;

  always_comb begin
    fb       = sig[W-1];
    sig_d    = sig;
    if (clr) begin
      sig_d = '0;
    end else if (en) begin
      sig_d[0] = fb ^ din[0];
      for (int i = 1; i < W; i++) sig_d[i] = sig[i-1] ^ din[i] ^ (TAPS[i] & fb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig <= '0;
    else        sig <= sig_d;
  end

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
#(
  parameter int CHAIN_LEN = 200,
  parameter int PAT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] pat_cnt,
  output logic             accept,
  output logic             scan_en,
  output logic             load_act,
  output logic             compact,
  output logic             done
);

  localparam int              CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  sbc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PAT_W-1:0] left_q, left_d;
  logic             unl_q, unl_d;
  logic             done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    unl_d  = unl_q;
    done_d = done;
    accept = 1'b0;
    case (st_q)
      SBC_IDLE: begin
        if (start && (pat_cnt != '0)) begin
          accept = 1'b1;
          st_d   = SBC_LOAD;
          cnt_d  = '0;
          left_d = pat_cnt;
          unl_d  = 1'b0;
          done_d = 1'b0;
        end
      end
      SBC_LOAD: begin
        if (cnt_q == LAST) begin
          st_d   = SBC_CAPT;
          cnt_d  = '0;
          left_d = left_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SBC_CAPT: begin
        unl_d = 1'b1;
        st_d  = (left_q == '0) ? SBC_FLUSH : SBC_LOAD;
      end
      SBC_FLUSH: begin
        if (cnt_q == LAST) begin
          st_d   = SBC_IDLE;
          cnt_d  = '0;
          unl_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SBC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SBC_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      unl_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      unl_q  <= unl_d;
      done   <= done_d;
    end
  end

  assign load_act = (st_q == SBC_LOAD);
  assign scan_en  = load_act || (st_q == SBC_FLUSH);
  assign compact  = (load_act && unl_q) || (st_q == SBC_FLUSH);

endmodule

// File: rtl/scanbist_ctrl.sv
module scanbist_ctrl #(
  parameter int NCHAINS   = 25,
  parameter int CHAIN_LEN = 200,
  parameter int PAT_W     = 16,
  parameter int GEN_W     = 16,
  parameter logic [GEN_W-1:0]   GEN_TAPS  = 16'hB400,
  parameter logic [GEN_W-1:0]   GEN_SEED  = 16'hACE1,
  parameter logic [NCHAINS-1:0] SIG_TAPS  = 25'h0000008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PAT_W-1:0]   pat_cnt,
  output logic               scan_en,
  output logic [NCHAINS-1:0] scan_in,
  input  logic [NCHAINS-1:0] scan_out,
  output logic               done,
  output logic [NCHAINS-1:0] signature
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept, load_act, compact;
  logic [GEN_W-1:0] gen_state;

  // Reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sbc_seq #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .pat_cnt(pat_cnt),
    .accept(accept), .scan_en(scan_en), .load_act(load_act),
    .compact(compact), .done(done)
  );

  sbc_lfsr #(.W(GEN_W), .TAPS(GEN_TAPS), .SEED(GEN_SEED)) u_gen (
    .clk(clk), .rst_n(rst_int_n), .seed_en(accept), .step_en(load_act),
    .state(gen_state)
  );

  sbc_phase_shift #(.LW(GEN_W), .NCH(NCHAINS)) u_ps (
    .gen(gen_state), .en(load_act), .chain_in(scan_in)
  );

  sbc_misr #(.W(NCHAINS), .TAPS(SIG_TAPS)) u_sig (
    .clk(clk), .rst_n(rst_int_n), .clr(accept), .en(compact),
    .din(scan_out), .sig(signature)
  );

endmodule

module scanbist_ctrl_chk #(
  parameter int NCHAINS   = 25,
  parameter int CHAIN_LEN = 200,
  parameter int PAT_W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [PAT_W-1:0]   pat_cnt,
  input logic               scan_en,
  input logic [NCHAINS-1:0] scan_in,
  input logic               done,
  input logic [NCHAINS-1:0] signature
);

  localparam int RUN_W = $clog2(CHAIN_LEN + 1) + 1;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (scan_en) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  AST_SHIFT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && run_len != '0) |-> (run_len == RUN_W'(CHAIN_LEN))); // R4
  AST_SHIFT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (run_len < RUN_W'(CHAIN_LEN))); // R4
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> (scan_en || done)); // R5
  AST_QUIET_STIM: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (scan_in == '0)); // R3
  AST_DONE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_en); // R8
  AST_DONE_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(scan_en)); // R8
  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(signature) && done)); // R9
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && pat_cnt == '0) |=> (done && !scan_en)); // R10

endmodule

bind scanbist_ctrl scanbist_ctrl_chk #(
  .NCHAINS(NCHAINS), .CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pat_cnt(pat_cnt),
  .scan_en(scan_en), .scan_in(scan_in), .done(done), .signature(signature)
);

// File: tb/scanbist_ctrl_test.sv
`timescale 1ns/1ps
module scanbist_ctrl_test;

  localparam int NCH = 25;
  localparam int L   = 200;
  localparam int PW  = 16;

  typedef struct packed {
    logic           sen;
    logic [NCH-1:0] sin;
    logic           comp;
    logic           first;
    logic           last;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [PW-1:0]  pat_cnt;
  logic           scan_en;
  logic [NCH-1:0] scan_in;
  logic [NCH-1:0] scan_out;
  logic           done;
  logic [NCH-1:0] signature;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  item_t q[$];
  logic [NCH-1:0] sig_m = '0;
  bit   [L-1:0]   chain [NCH];

  always #5 clk = ~clk;

  scanbist_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_cnt(pat_cnt),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .done(done), .signature(signature)
  );

  // Scan chains with a simple functional next-state for the capture clock
  always @(posedge clk) begin
    for (int k = 0; k < NCH; k++) begin
      if (scan_en) chain[k] <= {chain[k][L-2:0], scan_in[k]};
      else         chain[k] <= ~(chain[k] ^ {chain[(k+1)%NCH][L-2:0], 1'b0});
    end
  end
  always_comb for (int k = 0; k < NCH; k++) scan_out[k] = chain[k][L-1];

  function automatic logic [15:0] gen_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [NCH-1:0] stim(input logic [15:0] s);
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) begin
      int a, b;
      a = k % 16;
      b = (a + 1 + k / 16) % 16;
      r[k] = s[a] ^ s[b];
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] sig_step(input logic [NCH-1:0] s, input logic [NCH-1:0] d);
    logic [NCH-1:0] r;
    r[0] = s[NCH-1] ^ d[0];
    for (int i = 1; i < NCH; i++) r[i] = s[i-1] ^ d[i] ^ ((i == 3) ? s[NCH-1] : 1'b0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures < 30) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: start a run and push the expected per-cycle items
  task automatic run_start(input int n);
    logic [15:0] s;
    item_t it;
    @(negedge clk);
    start = 1'b1;
    pat_cnt = PW'(n);
    @(posedge clk);
    s = 16'hACE1;
    for (int p = 0; p < n; p++) begin
      for (int b = 0; b < L; b++) begin
        it = '{sen: 1'b1, sin: stim(s), comp: (p > 0), first: (p == 0 && b == 0), last: 1'b0};
        s = gen_next(s);
        q.push_back(it);
      end
      q.push_back('{sen: 1'b0, sin: '0, comp: 1'b0, first: 1'b0, last: 1'b0});
    end
    for (int b = 0; b < L; b++)
      q.push_back('{sen: 1'b1, sin: '0, comp: 1'b1, first: 1'b0, last: 1'b0});
    q.push_back('{sen: 1'b0, sin: '0, comp: 1'b0, first: 1'b0, last: 1'b1});
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.first) sig_m = '0;
      chk(scan_en == it.sen, "R4 R5 R6 scan_en timeline", 64'(scan_en), 64'(it.sen));
      chk(scan_in == it.sin, "R2 R3 scan_in stimulus", 64'(scan_in), 64'(it.sin));
      if (it.last) begin
        chk(done == 1'b1, "R8 done after final unload", 64'(done), 64'd1);
        chk(signature == sig_m, "R7 signature", 64'(signature), 64'(sig_m));
      end else begin
        chk(done == 1'b0, "R12 done low during run", 64'(done), 64'd0);
      end
      if (it.comp) sig_m = sig_step(sig_m, scan_out);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] held;
    rst_n = 1'b0;
    start = 1'b0;
    pat_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk(scan_en == 1'b0 && done == 1'b0, "R1 reset scan_en/done", {scan_en, done}, 64'd0);
    chk(signature == '0 && scan_in == '0, "R1 reset signature/scan_in", 64'(signature), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scan_en == 1'b0 && done == 1'b0 && signature == '0, "R1 idle after reset",
        {scan_en, done, 25'(signature)}, 64'd0);

    // Single pattern run
    run_start(1);
    wait (q.size() == 0);
    held = signature;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(done == 1'b1 && signature == held, "R9 hold after run", 64'(signature), 64'(held));
    end

    // R10: start with zero count is ignored
    @(negedge clk);
    start = 1'b1;
    pat_cnt = '0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(scan_en == 1'b0, "R10 zero-count start scan_en", 64'(scan_en), 64'd0);
      chk(done == 1'b1 && signature == held, "R10 zero-count start state", 64'(signature), 64'(held));
    end

    // Three patterns with a second start and a changed count mid-run (R10 R11)
    run_start(3);
    repeat (50) @(negedge clk);
    start = 1'b1;
    pat_cnt = 16'd7;
    @(negedge clk);
    start = 1'b0;
    pat_cnt = 16'd1;
    repeat (300) @(negedge clk);
    start = 1'b1;
    pat_cnt = 16'd2;
    @(negedge clk);
    start = 1'b0;
    wait (q.size() == 0);
    chk(done == 1'b1, "R10 R11 run length unaffected by mid-run start/count", 64'(done), 64'd1);

    // Two patterns: signature restarts from zero (R7), done cleared (R12)
    run_start(2);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    chk(scan_en == 1'b0 && done == 1'b1, "R8 R9 idle after last run", {scan_en, done}, 64'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule